// File: doc/BRIEF.md
# Serial-Word EEPROM Behavioural Model

This block is a synthesizable stand-in for a small serial EEPROM organised as 16-bit words. A bus master drives a chip select, a serial clock and a data-in line, and the block drives one data-out line. The block stores 2**AW words in an internal register array. The address width AW is a parameter, and the supported values are 6 and 8. It is meant to be placed in a bench or in an emulation build, where it acts as a partner that answers a master's read and programming sequences correctly.

The serial clock is sampled by the system clock `clk`. The block treats each low-to-high transition seen on `sk` as one bit time. A command has four parts, sent in this order:

- a start bit of 1;
- a 2-bit opcode;
- AW address bits, most significant first;
- 16 data bits, for the two commands that carry data.

Programming commands take effect when chip select falls after a complete, enabled command. After that, a counter holds the device busy for BUSY_CYC system clocks. While the device is busy and chip select is high, the data-out line reports the busy state.

Top module: `uwire_eeprom_model`

## Requirements
- R1: While chip select is high, any number of sampled bits equal to 0 before the first 1 are discarded. The first 1 starts a command. Rising serial-clock edges while chip select is low have no effect.
- R2: After the start bit, the next two bits form the opcode, first bit in the upper position. The following AW bits form the address, most significant first. AW is 6 or 8.
- R3: For opcode 10 (read), `dout` is 0 as soon as the last address bit has been taken. On each of the next 16 rising serial-clock edges, `dout` presents the next bit of the addressed word, starting from bit 15.
- R4: Opcode 01 (write) takes 16 data bits after the address, most significant first. When chip select falls, it stores them at the address.
- R5: Opcode 11 (erase) sets the addressed word to 16'hFFFF when chip select falls.
- R6: For opcode 00, the top two address bits choose the action and the other address bits are ignored. Value 11 sets the program-enable latch. Value 00 clears it. Neither of these two actions starts a busy interval.
- R7: Opcode 00 with top address bits 10 (erase-all) sets every word to 16'hFFFF.
- R8: Opcode 00 with top address bits 01 (write-all) takes 16 data bits and stores them in every word.
- R9: When the program-enable latch is clear, write, erase, erase-all and write-all change no word. They also start no busy interval.
- R10: An enabled programming command starts a busy interval of BUSY_CYC clocks when chip select falls. After chip select is raised again, `dout` is 0 while busy and 1 once the interval has finished. This status holds until the next start bit. A start bit is not accepted while busy.
- R11: If chip select drops before a command is complete, the partial command is discarded and the block waits for a new start bit.
- R12: Reset clears the program-enable latch. `dout` is 0 whenever neither a read nor a status report is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; bits are taken on its rising transitions |
| di | input | 1 | Serial data from the master |
| dout | output | 1 | Serial read data or ready/busy status |

## Verification
A rising `sk` edge is seen at the first `clk` edge where `sk` is high and was low one cycle earlier. Read data and the leading zero change at that same edge. The bench holds `sk` high for two clocks and samples `dout` only after that, so every read bit is observed one full cycle after it settles.

The busy interval starts at the `clk` edge that first sees chip select low. The bench raises chip select three cycles later and checks `dout` for 0 on the next falling clock edge. It then counts clocks until `dout` turns to 1 and accepts a count inside a window around BUSY_CYC. Ignored programming commands are checked through the same status pin and then by reading the word back.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    PG_WORD,
    PG_ERASE,
    PG_ERALL,
    PG_WRALL
  } pg_op_e;
endpackage

// File: rtl/uwe_edge.sv
module uwe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk_i,
  input  logic cs_i,
  output logic sk_rise_o,
  output logic cs_fall_o
);
  logic sk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
    end
  end

  assign sk_rise_o = sk_i & ~sk_q;
  assign cs_fall_o = cs_q & ~cs_i;
endmodule

// File: rtl/uwe_rx.sv
module uwe_rx
  import uwe_pkg::*;
#(
  parameter int AW = 6,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          di_i,
  input  logic          sk_rise_i,
  input  logic          cs_fall_i,
  input  logic          busy_i,
  input  logic [WW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [WW-1:0] wdata_o,
  output pg_op_e        op_o,
  output logic          commit_o,
  output logic          start_o,
  output logic          rd_act_o,
  output logic          rd_bit_o
);
  localparam int CW = $clog2(WW);
  localparam logic [CW-1:0] LAST_A = CW'(AW - 1);
  localparam logic [CW-1:0] LAST_D = CW'(WW - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    opc_q, opc_d;
  logic [AW-1:0] addr_q, addr_d, addr_nx;
  logic [WW-1:0] data_q, data_d;
  logic [WW-1:0] sh_q, sh_d;
  pg_op_e        op_q, op_d;
  logic          ready_q, ready_d;
  logic          wen_q, wen_d;
  logic          load_q, load_d;
  logic          bit_q, bit_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    addr_d  = addr_q;
    data_d  = data_q;
    sh_d    = sh_q;
    op_d    = op_q;
    ready_d = ready_q;
    wen_d   = wen_q;
    load_d  = load_q;
    bit_d   = bit_q;
    start_o = 1'b0;
    addr_nx = {addr_q[AW-2:0], di_i};
    if (!cs_i) begin
      state_d = ST_IDLE;
      ready_d = 1'b0;
      load_d  = 1'b0;
      bit_d   = 1'b0;
    end else begin
      if (state_q == ST_READ && load_q) begin
        sh_d   = rdata_i;
        load_d = 1'b0;
      end
      if (sk_rise_i) begin
        case (state_q)
          ST_IDLE: begin
            if (di_i && !busy_i) begin
              state_d = ST_OPC;
              cnt_d   = '0;
              start_o = 1'b1;
            end
          end
          ST_OPC: begin
            opc_d = {opc_q[0], di_i};
            if (cnt_q == CW'(1)) begin
              state_d = ST_ADDR;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_d = addr_nx;
            if (cnt_q == LAST_A) begin
              cnt_d = '0;
              case (opc_q)
                2'b10: begin
                  state_d = ST_READ;
                  load_d  = 1'b1;
                  bit_d   = 1'b0;
                end
                2'b01: begin
                  state_d = ST_DATA;
                  op_d    = PG_WORD;
                end
                2'b11: begin
                  state_d = ST_HOLD;
                  op_d    = PG_ERASE;
                  ready_d = 1'b1;
                end
                default: begin
                  case (addr_nx[AW-1:AW-2])
                    2'b11: begin
                      state_d = ST_HOLD;
                      wen_d   = 1'b1;
                    end
                    2'b00: begin
                      state_d = ST_HOLD;
                      wen_d   = 1'b0;
                    end
                    2'b10: begin
                      state_d = ST_HOLD;
                      op_d    = PG_ERALL;
                      ready_d = 1'b1;
                    end
                    default: begin
                      state_d = ST_DATA;
                      op_d    = PG_WRALL;
                    end
                  endcase
                end
              endcase
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            data_d = {data_q[WW-2:0], di_i};
            if (cnt_q == LAST_D) begin
              state_d = ST_HOLD;
              ready_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_READ: begin
            bit_d = sh_q[WW-1];
            sh_d  = {sh_q[WW-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      sh_q    <= '0;
      op_q    <= PG_WORD;
      ready_q <= 1'b0;
      wen_q   <= 1'b0;
      load_q  <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      sh_q    <= sh_d;
      op_q    <= op_d;
      ready_q <= ready_d;
      wen_q   <= wen_d;
      load_q  <= load_d;
      bit_q   <= bit_d;
    end
  end

  assign addr_o   = addr_q;
  assign wdata_o  = data_q;
  assign op_o     = op_q;
  assign commit_o = cs_fall_i & ready_q & wen_q;
  assign rd_act_o = (state_q == ST_READ);
  assign rd_bit_o = bit_q;

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> state_q == ST_IDLE); // R11
  AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && state_q == ST_IDLE) |=> state_q == ST_IDLE); // R10
  AST_READ_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act_o) |-> !rd_bit_o); // R3
  AST_ENABLE_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_q) |-> $past(state_q) == ST_ADDR); // R6
endmodule

// File: rtl/uwe_busy.sv
module uwe_busy #(
  parameter int BUSY_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic start_i,
  output logic busy_o,
  output logic stat_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [BW-1:0] LOAD = BW'(BUSY_CYC);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          stat_q, stat_d;

  always_comb begin
    cnt_d  = cnt_q;
    stat_d = stat_q;
    if (commit_i) begin
      cnt_d  = LOAD;
      stat_d = 1'b1;
    end else begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      if (start_i) stat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign stat_o = stat_q;

  AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> busy_o); // R10
  AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !commit_i); // R10
endmodule

// File: rtl/uwe_mem.sv
module uwe_mem
  import uwe_pkg::*;
#(
  parameter int AW = 6,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          we_i,
  input  pg_op_e        op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] wdata_i,
  output logic [WW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] words [DEPTH];
  logic [DEPTH-1:0] hit;
  logic [WW-1:0] val;
  logic          all_sel;

  assign all_sel = (op_i == PG_ERALL) || (op_i == PG_WRALL);
  assign val     = ((op_i == PG_ERASE) || (op_i == PG_ERALL)) ? '1 : wdata_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = all_sel || (addr_i == AW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_i && hit[i]) words[i] <= val;
    end
  end

  assign rdata_o = words[addr_i];
endmodule

// File: rtl/uwire_eeprom_model.sv
module uwire_eeprom_model
  import uwe_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BUSY_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  logic rst_meta, rst_sync;
  logic sk_rise, cs_fall, busy, stat, commit, start, rd_act, rd_bit;
  logic [AW-1:0]     addr;
  logic [WORD_W-1:0] wdata, rdata;
  pg_op_e            op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  uwe_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_sync),
    .sk_i      (sk),
    .cs_i      (cs),
    .sk_rise_o (sk_rise),
    .cs_fall_o (cs_fall)
  );

  uwe_rx #(.AW(AW), .WW(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cs_i      (cs),
    .di_i      (di),
    .sk_rise_i (sk_rise),
    .cs_fall_i (cs_fall),
    .busy_i    (busy),
    .rdata_i   (rdata),
    .addr_o    (addr),
    .wdata_o   (wdata),
    .op_o      (op),
    .commit_o  (commit),
    .start_o   (start),
    .rd_act_o  (rd_act),
    .rd_bit_o  (rd_bit)
  );

  uwe_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk      (clk),
    .rst_n    (rst_sync),
    .commit_i (commit),
    .start_i  (start),
    .busy_o   (busy),
    .stat_o   (stat)
  );

  uwe_mem #(.AW(AW), .WW(WORD_W)) u_mem (
    .clk     (clk),
    .we_i    (commit),
    .op_i    (op),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign dout = rd_act ? rd_bit : (cs & stat & ~busy);

  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_sync)
    (!cs && !rd_act) |-> !dout); // R12
endmodule

// File: tb/uwire_eeprom_model_test.sv
module uwire_eeprom_model_test;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int BUSY  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uwire_eeprom_model #(.AW(AW), .BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    @(negedge clk); di = b; sk = 1'b0;
    @(negedge clk);
    @(negedge clk); sk = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] opc, input logic [AW-1:0] a);
    sk_bit(1'b1);
    sk_bit(opc[1]);
    sk_bit(opc[0]);
    for (int i = AW - 1; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) sk_bit(w[i]);
  endtask

  // Full command ending with chip select low; then the status phase is checked.
  task automatic prog(input string req, input logic [1:0] opc, input logic [AW-1:0] a,
                      input bit has_data, input logic [15:0] w, input bit expect_busy);
    int n;
    cs_up();
    send_hdr(opc, a);
    if (has_data) send_word(w);
    cs_down();
    cs_up();
    @(negedge clk);
    chk({req, " status busy"}, {15'd0, dout}, 16'd0);
    n = 0;
    while (dout !== 1'b1 && n < 4 * BUSY) begin
      @(negedge clk);
      n++;
    end
    if (expect_busy) begin
      chk({req, " R10 busy window"}, 16'(n >= BUSY - 6 && n <= BUSY + 2), 16'd1);
    end else begin
      chk({req, " R9 no busy started"}, {15'd0, dout}, 16'd0);
    end
    cs_down();
  endtask

  task automatic ctrl(input logic [1:0] top2);
    cs_up();
    send_hdr(2'b00, {top2, 4'b1010});
    cs_down();
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input int pre_zeros,
                    input logic [15:0] exp);
    logic [15:0] v;
    cs_up();
    for (int i = 0; i < pre_zeros; i++) sk_bit(1'b0);
    send_hdr(2'b10, a);
    chk({req, " R3 leading zero"}, {15'd0, dout}, 16'd0);
    v = '0;
    for (int i = 0; i < 16; i++) begin
      sk_bit(1'b0);
      v = {v[14:0], dout};
    end
    chk(req, v, exp);
    cs_down();
  endtask

  task automatic t_reset();
    chk("R12 dout after reset", {15'd0, dout}, 16'd0);
    cs_up();
    chk("R12 dout idle with cs high", {15'd0, dout}, 16'd0);
    cs_down();
  endtask

  task automatic t_fill();
    ctrl(2'b11);
    prog("R7 erase-all", 2'b00, 6'b100000, 1'b0, 16'h0, 1'b1);
    rd("R7 word 0", 6'd0, 0, 16'hFFFF);
    rd("R7 word 63", 6'd63, 0, 16'hFFFF);
    rd("R7 word 17", 6'd17, 0, 16'hFFFF);
  endtask

  task automatic t_write();
    prog("R4 write 5", 2'b01, 6'd5, 1'b1, 16'hA5A5, 1'b1);
    prog("R4 write 62", 2'b01, 6'd62, 1'b1, 16'h3C3C, 1'b1);
    rd("R4 R2 read 5", 6'd5, 0, 16'hA5A5);
    rd("R4 R2 read 62", 6'd62, 0, 16'h3C3C);
    rd("R2 neighbour 4 untouched", 6'd4, 0, 16'hFFFF);
    rd("R1 zeros before start", 6'd62, 3, 16'h3C3C);
  endtask

  task automatic t_erase();
    prog("R5 erase 5", 2'b11, 6'd5, 1'b0, 16'h0, 1'b1);
    rd("R5 word 5 ones", 6'd5, 0, 16'hFFFF);
    rd("R5 word 62 kept", 6'd62, 0, 16'h3C3C);
  endtask

  task automatic t_wrall();
    prog("R8 write-all", 2'b00, 6'b010000, 1'b1, 16'h1234, 1'b1);
    rd("R8 word 0", 6'd0, 0, 16'h1234);
    rd("R8 word 63", 6'd63, 0, 16'h1234);
  endtask

  task automatic t_abort();
    cs_up();
    send_hdr(2'b01, 6'd9);
    for (int i = 0; i < 8; i++) sk_bit(1'b0);
    cs_down();
    cs_up();
    @(negedge clk);
    chk("R11 no status after abort", {15'd0, dout}, 16'd0);
    cs_down();
    rd("R11 word 9 unchanged", 6'd9, 0, 16'h1234);
    // clocks with chip select low are ignored
    for (int i = 0; i < 4; i++) sk_bit(1'b1);
    rd("R1 clocks while deselected ignored", 6'd9, 0, 16'h1234);
  endtask

  task automatic t_protect();
    ctrl(2'b00);
    prog("R9 write while disabled", 2'b01, 6'd9, 1'b1, 16'h0F0F, 1'b0);
    rd("R9 R6 word 9 kept", 6'd9, 0, 16'h1234);
    prog("R9 erase-all while disabled", 2'b00, 6'b100000, 1'b0, 16'h0, 1'b0);
    rd("R9 word 3 kept", 6'd3, 0, 16'h1234);
    ctrl(2'b11);
    prog("R6 write after enable", 2'b01, 6'd9, 1'b1, 16'h5555, 1'b1);
    rd("R6 word 9 written", 6'd9, 0, 16'h5555);
  endtask

  task automatic t_reset_clears();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    prog("R12 write after reset", 2'b01, 6'd9, 1'b1, 16'hAAAA, 1'b0);
    rd("R12 enable cleared by reset", 6'd9, 0, 16'h5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_write();
    t_erase();
    t_wrall();
    t_abort();
    t_protect();
    t_reset_clears();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule